// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block sits between a bus master and the memory system and decides, for every access, whether it may proceed. It holds eight protection regions, each described by a base address, a size written as a power of two, an enable bit and two permission bits: whether writes are allowed, and whether unprivileged code may touch the region at all. An address falls inside a region only when it lies in that region's size-aligned window; region sizes start at 32 bytes.

When more than one enabled region covers the address, the region with the highest index decides, so a small high-numbered region can carve a guard window out of a larger low-numbered one. Addresses that no enabled region covers fall into a background rule that lets privileged requests through and faults the rest. The decision is combinational on the request inputs. Configuration is written one region at a time through a register-style port, and a write with an illegal size or a base that is not aligned to its size is refused and leaves the region unchanged.

Top module: `prot_checker`

## Requirements
- R1: There are eight regions, selected by `cfg_idx` values 0 to 7; an accepted configuration write changes the decision from the cycle after the clock edge that samples it, and not before.
- R2: The size code `cfg_log2` gives a region size of 2^`cfg_log2` bytes; a write whose code is below 5 or above 32 is refused and the addressed region keeps its previous contents.
- R3: A write whose `cfg_base` has any bit set below bit position `cfg_log2` is refused and the addressed region keeps its previous contents.
- R4: An enabled region matches an access when bits 31 down to `log2` of `acc_addr` equal the same bits of the region base; lower address bits play no part.
- R5: A region stored with its enable bit clear never matches, whatever its base and size.
- R6: When several regions match, `acc_hit` is 1 and `acc_region` reports the highest matching index, whose permission bits decide the access.
- R7: In the deciding region, a write is permitted only if its write-allowed bit is 1 and an unprivileged access only if its user-allowed bit is 1; a region with the write-allowed bit clear permits reads and faults writes.
- R8: When no enabled region matches, `acc_hit` is 0, `acc_region` is 0, and the access is permitted exactly when `acc_priv` is 1.
- R9: `acc_fault` is always the inverse of `acc_permit`, and both follow the request inputs within the same cycle.
- R10: After reset every region is disabled, so every access follows the background rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region being written |
| cfg_base | input | 32 | Region base address |
| cfg_log2 | input | 6 | Region size as log2 of bytes (5 to 32) |
| cfg_en | input | 1 | Region enable |
| cfg_wr_ok | input | 1 | Writes allowed in region |
| cfg_usr_ok | input | 1 | Unprivileged accesses allowed in region |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_permit | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| acc_hit | output | 1 | Some enabled region matched |
| acc_region | output | 3 | Index of the deciding region |

## Verification
The assertions take for granted that the configuration and request inputs are settled and known at each rising edge, and that the only way into region storage is the configuration port with its legality screen. The bench changes inputs shortly after a rising edge and compares against a behavioural model at the falling edge, so every sampled value is stable. Configuration writes include refused sizes and misaligned bases, nested and overlapping windows, a whole-space region and a disabled region, and the request stream aims at window edges where one address bit flips the outcome.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int unsigned PC_ADDR_W   = 32;
  localparam int unsigned PC_REGIONS  = 8;
  localparam int unsigned PC_MIN_LOG2 = 5;

  typedef struct packed {
    logic wr_ok;
    logic usr_ok;
  } pc_perm_t;
endpackage

// File: rtl/pc_cfg_check.sv
module pc_cfg_check #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOG2_W   = 6,
  parameter int unsigned MIN_LOG2 = 5
) (
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2,
  output logic              cfg_ok
);
  logic [ADDR_W-1:0] low_bits;
  logic              size_ok;

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      low_bits[b] = (b < int'(cfg_log2));
    end
    size_ok = (int'(cfg_log2) >= int'(MIN_LOG2)) && (int'(cfg_log2) <= int'(ADDR_W));
    cfg_ok  = size_ok && ((cfg_base & low_bits) == '0);
  end
endmodule

// File: rtl/pc_region_slot.sv
module pc_region_slot
  import prot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOG2_W   = 6,
  parameter int unsigned MIN_LOG2 = 5,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned SLOT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ok,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2,
  input  logic              cfg_en,
  input  pc_perm_t          cfg_perm,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output pc_perm_t          perm
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LOG2_W-1:0] log2_q, log2_d;
  logic              en_q, en_d;
  pc_perm_t          perm_q, perm_d;
  logic              sel, load;
  logic [ADDR_W-1:0] keep_mask;

  assign sel  = (cfg_idx == IDX_W'(SLOT));
  assign load = cfg_we && cfg_ok && sel;

  always_comb begin
    base_d = base_q;
    log2_d = log2_q;
    en_d   = en_q;
    perm_d = perm_q;
    if (load) begin
      base_d = cfg_base;
      log2_d = cfg_log2;
      en_d   = cfg_en;
      perm_d = cfg_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      log2_q <= LOG2_W'(MIN_LOG2);
      en_q   <= 1'b0;
      perm_q <= '0;
    end else if (load) begin
      base_q <= base_d;
      log2_q <= log2_d;
      en_q   <= en_d;
      perm_q <= perm_d;
    end
  end

  // address bits at or above the size code take part in the compare
  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      keep_mask[b] = (b >= int'(log2_q));
    end
  end

  assign hit  = en_q && (((acc_addr ^ base_q) & keep_mask) == '0);
  assign perm = perm_q;

  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(log2_q) >= int'(MIN_LOG2)) && (int'(log2_q) <= int'(ADDR_W)));

  p_refused_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel && !cfg_ok) |=> ($stable(base_q) && $stable(log2_q) && $stable(en_q) && $stable(perm_q)));

  p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q & ~keep_mask) == '0);

  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit);
endmodule

// File: rtl/pc_prio_pick.sv
module pc_prio_pick
  import prot_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     hit_vec,
  input  pc_perm_t [N-1:0] perm_vec,
  output logic             any,
  output logic [IDX_W-1:0] win_idx,
  output pc_perm_t         win_perm
);
  // ascending scan: a later (higher) index overrides an earlier one
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_perm = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (hit_vec[i]) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_perm = perm_vec[i];
      end
    end
  end
endmodule

// File: rtl/prot_checker.sv
module prot_checker
  import prot_pkg::*;
#(
  parameter int unsigned ADDR_W   = PC_ADDR_W,
  parameter int unsigned REGIONS  = PC_REGIONS,
  parameter int unsigned MIN_LOG2 = PC_MIN_LOG2,
  localparam int unsigned IDX_W   = $clog2(REGIONS),
  localparam int unsigned LOG2_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2,
  input  logic              cfg_en,
  input  logic              cfg_wr_ok,
  input  logic              cfg_usr_ok,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic              acc_permit,
  output logic              acc_fault,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_region
);
  logic                   cfg_ok;
  pc_perm_t               cfg_perm;
  logic [REGIONS-1:0]     hit_vec;
  pc_perm_t [REGIONS-1:0] perm_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  pc_perm_t               win_perm;
  logic                   rule_ok;

  assign cfg_perm = '{wr_ok: cfg_wr_ok, usr_ok: cfg_usr_ok};

  pc_cfg_check #(.ADDR_W(ADDR_W), .LOG2_W(LOG2_W), .MIN_LOG2(MIN_LOG2)) u_chk (
    .cfg_base (cfg_base),
    .cfg_log2 (cfg_log2),
    .cfg_ok   (cfg_ok)
  );

  for (genvar g = 0; g < int'(REGIONS); g++) begin : g_slot
    pc_region_slot #(
      .ADDR_W(ADDR_W), .LOG2_W(LOG2_W), .MIN_LOG2(MIN_LOG2),
      .IDX_W(IDX_W), .SLOT(g)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_ok   (cfg_ok),
      .cfg_idx  (cfg_idx),
      .cfg_base (cfg_base),
      .cfg_log2 (cfg_log2),
      .cfg_en   (cfg_en),
      .cfg_perm (cfg_perm),
      .acc_addr (acc_addr),
      .hit      (hit_vec[g]),
      .perm     (perm_vec[g])
    );
  end

  pc_prio_pick #(.N(REGIONS), .IDX_W(IDX_W)) u_pick (
    .hit_vec  (hit_vec),
    .perm_vec (perm_vec),
    .any      (any_hit),
    .win_idx  (win_idx),
    .win_perm (win_perm)
  );

  always_comb begin
    if (any_hit) begin
      rule_ok = (acc_priv || win_perm.usr_ok) && (!acc_write || win_perm.wr_ok);
    end else begin
      rule_ok = acc_priv;
    end
  end

  assign acc_permit = rule_ok;
  assign acc_fault  = !rule_ok;
  assign acc_hit    = any_hit;
  assign acc_region = win_idx;

  p_top_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[win_idx] && (((hit_vec >> win_idx) >> 1) == '0)));

  p_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && acc_write && !perm_vec[win_idx].wr_ok) |-> acc_fault);

  p_background_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> ((acc_permit == acc_priv) && (acc_region == '0)));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_permit != acc_fault);
endmodule

// File: tb/tb_prot_checker.sv
module tb_prot_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [5:0]  cfg_log2 = 6'd5;
  logic        cfg_en = 1'b0;
  logic        cfg_wr_ok = 1'b0;
  logic        cfg_usr_ok = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b0;
  logic        acc_permit, acc_fault, acc_hit;
  logic [2:0]  acc_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] m_base [8];
  int          m_lg   [8];
  bit          m_en   [8];
  bit          m_wr   [8];
  bit          m_usr  [8];

  prot_checker dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2), .cfg_en(cfg_en),
    .cfg_wr_ok(cfg_wr_ok), .cfg_usr_ok(cfg_usr_ok), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_priv(acc_priv), .acc_permit(acc_permit),
    .acc_fault(acc_fault), .acc_hit(acc_hit), .acc_region(acc_region)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit legal(logic [31:0] b, int lg);
    longint lowm;
    if (lg < 5 || lg > 32) return 1'b0;
    lowm = (64'sd1 <<< lg) - 1;
    return (longint'(b) & lowm) == 0;
  endfunction

  // reference model update (R1, R2, R3, R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_base[i] = 0; m_lg[i] = 5; m_en[i] = 0; m_wr[i] = 0; m_usr[i] = 0;
      end
    end else if (cfg_we && legal(cfg_base, int'(cfg_log2))) begin
      m_base[cfg_idx] = cfg_base;
      m_lg[cfg_idx]   = int'(cfg_log2);
      m_en[cfg_idx]   = cfg_en;
      m_wr[cfg_idx]   = cfg_wr_ok;
      m_usr[cfg_idx]  = cfg_usr_ok;
    end
  end

  // compare on every clock, at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_hit, e_ok;
      int e_idx;
      string tag;
      e_hit = 0; e_idx = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_en[i] && ((longint'(acc_addr) >> m_lg[i]) == (longint'(m_base[i]) >> m_lg[i]))) begin
          e_hit = 1; e_idx = i;
        end
      end
      if (e_hit) begin
        e_ok = (acc_priv || m_usr[e_idx]) && (!acc_write || m_wr[e_idx]);
        tag = (acc_write && !m_wr[e_idx]) ? "R7" : "R6";
      end else begin
        e_ok = acc_priv;
        tag = "R8";
      end
      checks++;
      if (acc_hit !== e_hit || acc_region !== 3'(e_idx) ||
          acc_permit !== e_ok || acc_fault !== !e_ok) begin
        fails++;
        $display("FAIL %s/R9 addr=%h wr=%0b pr=%0b: hit=%0b reg=%0d permit=%0b fault=%0b, expected hit=%0b reg=%0d permit=%0b fault=%0b",
                 tag, acc_addr, acc_write, acc_priv, acc_hit, acc_region, acc_permit, acc_fault,
                 e_hit, e_idx, e_ok, !e_ok);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input int idx, input logic [31:0] b, input int lg,
                     input bit en, input bit wr, input bit usr);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = b; cfg_log2 = 6'(lg);
    cfg_en = en; cfg_wr_ok = wr; cfg_usr_ok = usr;
    tick();
    cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input bit wr, input bit pr);
    acc_addr = a; acc_write = wr; acc_priv = pr;
    tick();
  endtask

  task automatic sweep(input logic [31:0] a);
    for (int k = 0; k < 4; k++) acc(a, k[0], k[1]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: nothing enabled, background rule everywhere (R8)
    sweep(32'h0000_0000); sweep(32'hFFFF_FFE0);
    // R1: region 0 read-only user code; checked at the cycle before and after the edge
    acc_addr = 32'h0000_1234; acc_write = 0; acc_priv = 0;
    cfg(0, 32'h0000_0000, 16, 1, 0, 1);
    sweep(32'h0000_1234); sweep(32'h0000_FFFF); sweep(32'h0001_0000); // R4 edge
    // R6: nested windows
    cfg(1, 32'h2000_0000, 12, 1, 1, 1);
    cfg(3, 32'h2000_0800, 8, 1, 1, 0);
    cfg(7, 32'h2000_0800, 5, 1, 0, 0);
    sweep(32'h2000_0000); sweep(32'h2000_07FF); sweep(32'h2000_0800);
    sweep(32'h2000_081F); sweep(32'h2000_0820); sweep(32'h2000_0900); sweep(32'h2000_1000);
    // R2: refused sizes; R3: misaligned base — region 2 stays disabled
    cfg(2, 32'h3000_0000, 4, 1, 1, 1);
    sweep(32'h3000_0000);
    cfg(2, 32'h3000_0000, 33, 1, 1, 1);
    sweep(32'h3000_0004);
    cfg(2, 32'h3000_0010, 8, 1, 1, 1);
    sweep(32'h3000_0010);
    // R2: refused write to an enabled region leaves it intact
    cfg(1, 32'h5000_0000, 3, 1, 0, 0);
    sweep(32'h2000_0004); sweep(32'h5000_0000);
    // R5: disabled region never matches
    cfg(4, 32'h4000_0000, 20, 0, 1, 1);
    sweep(32'h4000_0100);
    // R4: whole-space region, then nested winners above it
    cfg(5, 32'h0000_0000, 32, 1, 0, 1);
    sweep(32'h8765_4321); sweep(32'h2000_0810);
    cfg(6, 32'h7000_0000, 28, 1, 1, 0);
    sweep(32'h7FFF_FFFF); sweep(32'h8000_0000);
    cfg(5, 32'h0000_0000, 32, 0, 0, 1);
    sweep(32'h8765_4321);
    // mixed pattern near window edges
    for (int n = 0; n < 400; n++) begin
      logic [31:0] bases [6];
      logic [31:0] a;
      bases = '{32'h0000_0000, 32'h2000_0000, 32'h2000_0800, 32'h3000_0000, 32'h7000_0000, 32'h4000_0000};
      a = bases[$urandom_range(0, 5)] + 32'($urandom_range(0, 64)) - 32'd32;
      if (n % 7 == 0) a = a ^ (32'd1 << $urandom_range(0, 31));
      if (n % 50 == 0)
        cfg($urandom_range(0, 7), bases[$urandom_range(0, 5)], $urandom_range(3, 33),
            1'($urandom), 1'($urandom), 1'($urandom));
      acc(a, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule